// File: doc/BRIEF.md
# Shared External Interrupt Source Conditioner

This block prepares one external interrupt source for an interrupt controller. Two requesters share the source. One is a physical request pad. The other is a virtual legacy interrupt wire, which is set by PCIe INTx Assert messages and cleared by INTx Deassert messages. The block merges the two requesters and applies the programmed polarity and sense (edge or level). It then presents a single pending request to the downstream priority logic.

The pad level is asynchronous, so it passes through a synchronizer first. The pin can be put in interrupt-input mode or general-purpose I/O mode. In general-purpose I/O mode the pad is replaced by a constant low level. When the virtual wire is asserted, it drives the level that the polarity bit marks as active. It does not drive a fixed level. In level mode the pending request follows the merged level. In edge mode it is latched on the selected edge and held until an acknowledge strobe clears it. The sense setting also tells whether the source may be routed to a direct interrupt output.

Top module: `irq_src_cond`

## Requirements
- R1: After reset, `reqPending` is 0 and the virtual wire is deasserted, so an active-high level-mode source with an idle pad reports no request.
- R2: `senseLevel` and `directRouteOk` both equal `cfgLevel`. Here 1 means level-sensitive, and that mode alone makes the source eligible for direct routing.
- R3: A change on `padIn` reaches `reqPending` on the third rising clock edge after the change: two synchronizer stages plus the pending register.
- R4: In level mode (`cfgLevel`=1), `reqPending` is 1 while the merged level equals the active level. That level is high when `cfgPolHigh`=1 and low when `cfgPolHigh`=0.
- R5: In edge mode (`cfgLevel`=0), `reqPending` is set only on the selected transition of the merged level: rising for `cfgPolHigh`=1, falling for `cfgPolHigh`=0. It then stays set with no further edge.
- R6: In edge mode, a one-cycle `ack` clears `reqPending` on the next edge. If a selected edge is detected in the same cycle as `ack`, the pending bit stays set.
- R7: In level mode, an `intxAssert` strobe drives the virtual wire to the programmed active level, and `reqPending` rises on the second clock edge. An `intxDeassert` strobe returns the wire to the inactive level, and the request drops with the same latency. This holds for both polarities.
- R8: If `intxAssert` and `intxDeassert` are high in the same cycle, the virtual wire ends up asserted.
- R9: In edge mode, the virtual wire is blocked from the merged level, so an INTx Assert never sets `reqPending`.
- R10: With `pinIsIrq`=0 (general-purpose I/O), `padIn` has no effect, and the pad contributes a constant low level. INTx then works with `cfgPolHigh`=1. With `cfgPolHigh`=0 in level mode, the source reads as permanently active.
- R11: The pad and the virtual wire are combined so that either one being active holds the request. In level mode the request drops only once both are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| padIn | input | 1 | Asynchronous request pad level |
| pinIsIrq | input | 1 | 1: pin is an interrupt input; 0: general-purpose I/O |
| intxAssert | input | 1 | One-cycle strobe: INTx Assert message received |
| intxDeassert | input | 1 | One-cycle strobe: INTx Deassert message received |
| cfgPolHigh | input | 1 | Polarity: 1 active-high or rising edge, 0 active-low or falling edge |
| cfgLevel | input | 1 | Sense: 1 level-sensitive, 0 edge-sensitive |
| ack | input | 1 | Acknowledge strobe; clears an edge-latched request |
| reqPending | output | 1 | Pending request to the priority logic |
| senseLevel | output | 1 | Status: source is level-sensitive |
| directRouteOk | output | 1 | Source may be routed to the direct interrupt output |

## Verification
In edge mode, an edge can be detected in the same cycle that `ack` arrives. To provoke this, the bench raises the pad and then drives `ack` in exactly the cycle where the synchronized level has changed but the pending register has not yet been updated. The request must still be pending afterwards, and a later lone acknowledge must clear it. The virtual wire's assert and deassert strobes are also driven together in one cycle. That case is judged by whether a level-mode request appears two edges later.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic vwSet;    // drive virtual wire to active
    logic vwClr;    // return virtual wire to inactive
    logic pendSet;  // set pending request
    logic pendClr;  // clear pending request
  } condStrb_t;

  localparam int DefaultSyncStages = 2;

endpackage

// File: rtl/irq_src_datapath.sv
module irq_src_datapath
  import irq_src_pkg::*;
#(
  parameter int SyncStages = DefaultSyncStages
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      padIn,
  input  logic      pinIsIrq,
  input  logic      cfgPolHigh,
  input  logic      cfgLevel,
  input  condStrb_t strb,
  output logic      combLvl,
  output logic      combPrev,
  output logic      vwireOn,
  output logic      reqPending
);

  localparam int LastStage = SyncStages - 1;

  logic [SyncStages-1:0] syncQ;
  logic padCond;
  logic vwLvl;

  // Pad synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SyncStages-2:0], padIn};
  end

  // GPIO mode forces a constant low contribution
  assign padCond = pinIsIrq & syncQ[LastStage];

  // Virtual wire drives the programmed active level, blocked in edge mode
  assign vwLvl = (vwireOn & cfgLevel) ? cfgPolHigh : ~cfgPolHigh;

  // Merge: either requester at the active level activates the source
  assign combLvl = cfgPolHigh ? (padCond | vwLvl) : (padCond & vwLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vwireOn    <= 1'b0;
      combPrev   <= 1'b0;
      reqPending <= 1'b0;
    end else begin
      if (strb.vwSet)      vwireOn <= 1'b1;
      else if (strb.vwClr) vwireOn <= 1'b0;
      combPrev <= combLvl;
      if (strb.pendSet)      reqPending <= 1'b1;
      else if (strb.pendClr) reqPending <= 1'b0;
    end
  end

  AST_GPIO_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!pinIsIrq && !cfgLevel) |-> !combLvl); // R9

endmodule

// File: rtl/irq_src_control.sv
module irq_src_control
  import irq_src_pkg::*;
(
  input  logic      intxAssert,
  input  logic      intxDeassert,
  input  logic      cfgPolHigh,
  input  logic      cfgLevel,
  input  logic      ack,
  input  logic      combLvl,
  input  logic      combPrev,
  output condStrb_t strb
);

  logic activeNow;
  logic activePrev;
  logic edgeHit;

  assign activeNow  = (combLvl == cfgPolHigh);
  assign activePrev = (combPrev == cfgPolHigh);
  assign edgeHit    = activeNow & ~activePrev;

  always_comb begin
    strb.vwSet = intxAssert;
    strb.vwClr = intxDeassert & ~intxAssert;  // assert wins
    if (cfgLevel) begin
      strb.pendSet = activeNow;
      strb.pendClr = ~activeNow;
    end else begin
      strb.pendSet = edgeHit;
      strb.pendClr = ack & ~edgeHit;         // new edge beats acknowledge
    end
  end

endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_src_pkg::*;
#(
  parameter int SyncStages = DefaultSyncStages
) (
  input  logic clk,
  input  logic rstN,
  input  logic padIn,
  input  logic pinIsIrq,
  input  logic intxAssert,
  input  logic intxDeassert,
  input  logic cfgPolHigh,
  input  logic cfgLevel,
  input  logic ack,
  output logic reqPending,
  output logic senseLevel,
  output logic directRouteOk
);

  condStrb_t strb;
  logic combLvl;
  logic combPrev;
  logic vwireOn;

  irq_src_control u_ctrl (
    .intxAssert  (intxAssert),
    .intxDeassert(intxDeassert),
    .cfgPolHigh  (cfgPolHigh),
    .cfgLevel    (cfgLevel),
    .ack         (ack),
    .combLvl     (combLvl),
    .combPrev    (combPrev),
    .strb        (strb)
  );

  irq_src_datapath #(.SyncStages(SyncStages)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .padIn     (padIn),
    .pinIsIrq  (pinIsIrq),
    .cfgPolHigh(cfgPolHigh),
    .cfgLevel  (cfgLevel),
    .strb      (strb),
    .combLvl   (combLvl),
    .combPrev  (combPrev),
    .vwireOn   (vwireOn),
    .reqPending(reqPending)
  );

  assign senseLevel    = cfgLevel;
  assign directRouteOk = cfgLevel;

  AST_ASSERT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    intxAssert |=> vwireOn); // R8

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    cfgLevel |=> (reqPending == ($past(combLvl) == $past(cfgPolHigh)))); // R4

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLevel && reqPending && !ack) |=> reqPending); // R5

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLevel && ack && (combLvl == combPrev)) |=> !reqPending); // R6

endmodule

// File: tb/irq_src_cond_bench.sv
module irq_src_cond_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic padIn = 1'b0;
  logic pinIsIrq = 1'b1;
  logic intxAssert = 1'b0;
  logic intxDeassert = 1'b0;
  logic cfgPolHigh = 1'b1;
  logic cfgLevel = 1'b1;
  logic ack = 1'b0;
  logic reqPending;
  logic senseLevel;
  logic directRouteOk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_src_cond u_irq_src_cond (
    .clk(clk), .rstN(rstN), .padIn(padIn), .pinIsIrq(pinIsIrq),
    .intxAssert(intxAssert), .intxDeassert(intxDeassert),
    .cfgPolHigh(cfgPolHigh), .cfgLevel(cfgLevel), .ack(ack),
    .reqPending(reqPending), .senseLevel(senseLevel),
    .directRouteOk(directRouteOk)
  );

  task automatic check(input logic actual, input logic expected, input string what);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, actual, expected);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAssert();
    intxAssert = 1'b1; waitN(1); intxAssert = 1'b0;
  endtask

  task automatic pulseDeassert();
    intxDeassert = 1'b1; waitN(1); intxDeassert = 1'b0;
  endtask

  task automatic pulseAck();
    ack = 1'b1; waitN(1); ack = 1'b0;
  endtask

  task automatic t_reset();
    waitN(3); rstN = 1'b1; waitN(1);
    check(reqPending, 1'b0, "R1 pending after reset");
    check(senseLevel, 1'b1, "R2 senseLevel level mode");
    check(directRouteOk, 1'b1, "R2 route ok level mode");
  endtask

  task automatic t_level_polarity();
    padIn = 1'b1; waitN(2);
    check(reqPending, 1'b0, "R3 not yet after two edges");
    waitN(1);
    check(reqPending, 1'b1, "R3 pad reaches pending third edge");
    padIn = 1'b0; waitN(3);
    check(reqPending, 1'b0, "R4 active-high drops");
    cfgPolHigh = 1'b0; padIn = 1'b1; waitN(3);
    check(reqPending, 1'b0, "R4 active-low pad high idle");
    padIn = 1'b0; waitN(3);
    check(reqPending, 1'b1, "R4 active-low pad low pending");
    padIn = 1'b1; waitN(3);
    check(reqPending, 1'b0, "R4 active-low released");
  endtask

  task automatic t_edge();
    cfgPolHigh = 1'b1; padIn = 1'b0; waitN(4);
    cfgLevel = 1'b0; waitN(1);
    check(senseLevel, 1'b0, "R2 senseLevel edge mode");
    check(directRouteOk, 1'b0, "R2 route blocked edge mode");
    padIn = 1'b1; waitN(3);
    check(reqPending, 1'b1, "R5 rising edge latches");
    padIn = 1'b0; waitN(3);
    check(reqPending, 1'b1, "R5 held after pad falls");
    pulseAck();
    check(reqPending, 1'b0, "R6 ack clears");
    padIn = 1'b1; waitN(3); pulseAck(); waitN(3);
    check(reqPending, 1'b0, "R5 steady high no re-set");
    cfgPolHigh = 1'b0; waitN(2);
    padIn = 1'b0; waitN(3);
    check(reqPending, 1'b1, "R5 falling edge latches pol0");
    pulseAck();
    padIn = 1'b1; waitN(3);
    check(reqPending, 1'b0, "R5 rising ignored pol0");
  endtask

  task automatic t_edge_ack_collide();
    cfgPolHigh = 1'b1; padIn = 1'b0; waitN(4); pulseAck();
    padIn = 1'b1; waitN(2);
    ack = 1'b1; waitN(1); ack = 1'b0;
    check(reqPending, 1'b1, "R6 edge beats simultaneous ack");
    pulseAck();
    check(reqPending, 1'b0, "R6 later ack clears");
  endtask

  task automatic t_intx_level();
    cfgLevel = 1'b1; cfgPolHigh = 1'b1; padIn = 1'b0; waitN(4);
    pulseAssert();
    check(reqPending, 1'b0, "R7 not yet after one edge");
    waitN(1);
    check(reqPending, 1'b1, "R7 INTx assert pol1");
    pulseDeassert(); waitN(1);
    check(reqPending, 1'b0, "R7 INTx deassert pol1");
    padIn = 1'b1; waitN(3);
    pulseAssert(); waitN(1);
    padIn = 1'b0; waitN(3);
    check(reqPending, 1'b1, "R11 INTx holds after pad release");
    pulseDeassert(); waitN(1);
    check(reqPending, 1'b0, "R11 both inactive drops");
    padIn = 1'b1; cfgPolHigh = 1'b0; waitN(4);
    check(reqPending, 1'b0, "R7 pol0 idle");
    pulseAssert(); waitN(1);
    check(reqPending, 1'b1, "R7 INTx assert pol0");
    pulseDeassert(); waitN(1);
    check(reqPending, 1'b0, "R7 INTx deassert pol0");
    intxAssert = 1'b1; intxDeassert = 1'b1; waitN(1);
    intxAssert = 1'b0; intxDeassert = 1'b0; waitN(1);
    check(reqPending, 1'b1, "R8 assert wins collision");
    pulseDeassert(); waitN(1);
    check(reqPending, 1'b0, "R8 cleared afterwards");
  endtask

  task automatic t_intx_edge_blocked();
    cfgPolHigh = 1'b1; padIn = 1'b0; waitN(4);
    cfgLevel = 1'b0; waitN(1); pulseAck();
    pulseAssert(); waitN(3);
    check(reqPending, 1'b0, "R9 INTx blocked in edge mode");
    pulseDeassert(); waitN(1);
    cfgLevel = 1'b1; waitN(2);
    check(reqPending, 1'b0, "R9 idle back in level mode");
  endtask

  task automatic t_gpio();
    pinIsIrq = 1'b0; cfgPolHigh = 1'b1; padIn = 1'b1; waitN(4);
    check(reqPending, 1'b0, "R10 pad ignored in GPIO mode");
    pulseAssert(); waitN(1);
    check(reqPending, 1'b1, "R10 INTx works GPIO pol1");
    pulseDeassert(); waitN(1);
    check(reqPending, 1'b0, "R10 INTx released GPIO pol1");
    cfgPolHigh = 1'b0; waitN(2);
    check(reqPending, 1'b1, "R10 GPIO pol0 reads active");
    cfgPolHigh = 1'b1; pinIsIrq = 1'b1; waitN(4);
  endtask

  initial begin
    t_reset();
    t_level_polarity();
    t_edge();
    t_edge_ack_collide();
    t_intx_level();
    t_intx_edge_blocked();
    t_gpio();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule